// File: doc/BRIEF.md
# D-PHY Link Timing Calculator

This block turns one number, the per-lane bit rate of a serial display link in whole megahertz, into the complete set of D-PHY timing counts that a display transmitter needs, each expressed in byte-clock cycles. It covers the data-lane entry, exit and turnaround timings and the clock-lane timings. The counts are packed into four 32-bit configuration words that the transmitter loads without further processing. The rate is the pixel clock times the bits per pixel, divided by the lane count and rounded up. The bits per pixel are 16 for 5-6-5 colour, 18 for packed 6-6-6 and 24 otherwise. The rate reaches this block already in MHz and already rounded up.

A one-cycle start pulse captures the rate and begins a computation. Every count is an affine function of the rate divided by 8000, or is chained off one of those quotients. There are four such divisions in total. They run one after another on a single shared shift-and-subtract divider, which avoids four wide combinational dividers. When all four words are updated, a one-cycle done strobe marks them valid. The words hold until the next computation completes.

Top module: `dphy_timing_calc`

## Requirements
- R1: After reset, all four timing words, done, busy and overflow are zero.
- R2: A start pulse while idle captures rateMhz, raises busy on the next cycle and, after a fixed number of cycles that does not depend on the rate, raises done for exactly one cycle; busy is low again on the cycle after done.
- R3: Word 0 holds lpx = floor(60·r/8000)+1 in bits 7:0, hsPrep = floor((80·r+4000)/8000) in bits 15:8, hsZero = floor((170·r+10000)/8000)+1−hsPrep in bits 23:16 and hsTrail = hsPrep+1 in bits 31:24, where r is the captured rate.
- R4: Word 1 holds taGo = 4·lpx−2 in bits 7:0, taSure = lpx+2 in bits 15:8, taGet = 4·lpx in bits 23:16 and hsExit = 2·lpx+1 in bits 31:24.
- R5: Word 2 holds zero in bits 7:0, the constant 1 in bits 15:8, clkZero = 4·clkPrep in bits 23:16 and clkTrail = clkPrep in bits 31:24, where clkPrep = floor(70·r/8000).
- R6: Word 3 holds clkPrep in bits 7:0, clkPost = clkPrep+8 in bits 15:8, clkExit = 2·clkPrep in bits 23:16 and zero in bits 31:24.
- R7: A start pulse while busy is ignored: the running computation is neither restarted nor given the new rate, and no extra done strobe follows.
- R8: Each field is its count truncated to 8 bits; overflow, updated with the words, is 1 when any count exceeds 255 or hsZero would be negative, and stays 0 for every 12-bit rate.
- R9: The words and overflow change only on the clock edge that raises done and otherwise hold their values, whatever happens on rateMhz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compute from rateMhz |
| rateMhz | input | 12 | Per-lane bit rate in MHz, rounded up |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe: words just updated |
| overflow | output | 1 | A count exceeded 8 bits or hsZero went negative |
| timingWord0 | output | 32 | Data-lane entry timings |
| timingWord1 | output | 32 | Turnaround and exit timings |
| timingWord2 | output | 32 | Clock-lane zero and trail timings |
| timingWord3 | output | 32 | Clock-lane prepare, post and exit timings |

## Verification
The assertions assume that start is a single-cycle pulse and that reset is held for at least one clock edge. They also assume that the rate lies in the 12-bit range, so that the chained relations between fields, such as taGet being four times lpx, hold modulo 256. The stimulus drives start for one cycle at a time from the falling clock edge. It keeps every rate inside 0 to 4095, including both ends of that range. It moves rateMhz only while the block is idle or while a start is deliberately being ignored, so the captured value is always the one the bench intends.

// File: rtl/dphy_timing_pkg.sv
package dphy_timing_pkg;

  localparam int NUM_DIVS = 4;

  // Affine numerators: quotient k = (rate * MUL + ADD) / divisor
  localparam int LPX_MUL     = 60;
  localparam int LPX_ADD     = 0;
  localparam int HSPREP_MUL  = 80;
  localparam int HSPREP_ADD  = 4000;
  localparam int HSZERO_MUL  = 170;
  localparam int HSZERO_ADD  = 10000;
  localparam int CLKPREP_MUL = 70;
  localparam int CLKPREP_ADD = 0;

  typedef enum logic [1:0] {
    DIV_LPX     = 2'd0,
    DIV_HSPREP  = 2'd1,
    DIV_HSZERO  = 2'd2,
    DIV_CLKPREP = 2'd3
  } divSel_e;

  typedef struct packed {
    logic    loadRate;
    logic    divStart;
    logic    capture;
    logic    pack;
    divSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/dphy_serial_divider.sv
module dphy_serial_divider #(
  parameter int NUM_W   = 21,
  parameter int DIVISOR = 8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int DW  = $clog2(DIVISOR + 1);
  localparam int CNW = $clog2(NUM_W + 1);

  logic [DW-1:0]  remR;
  logic [NUM_W-1:0] quoR;
  logic [CNW-1:0] cntR;
  logic           runR;
  logic           doneR;

  logic [DW:0] shifted;
  logic [DW:0] trial;
  logic        fits;

  always_comb begin
    shifted = {remR, quoR[NUM_W-1]};
    trial   = shifted - (DW+1)'(DIVISOR);
    fits    = (shifted >= (DW+1)'(DIVISOR));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      cntR  <= '0;
      runR  <= 1'b0;
      doneR <= 1'b0;
    end else if (start) begin
      remR  <= '0;
      quoR  <= numer;
      cntR  <= CNW'(NUM_W);
      runR  <= 1'b1;
      doneR <= 1'b0;
    end else if (runR) begin
      remR  <= fits ? trial[DW-1:0] : shifted[DW-1:0];
      quoR  <= {quoR[NUM_W-2:0], fits};
      cntR  <= cntR - CNW'(1);
      if (cntR == CNW'(1)) begin
        runR  <= 1'b0;
        doneR <= 1'b1;
      end
    end else begin
      doneR <= 1'b0;
    end
  end

  assign quot = quoR;
  assign done = doneR;

endmodule

// File: rtl/dphy_timing_ctrl.sv
module dphy_timing_ctrl
  import dphy_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divDone,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_PACK  = 3'd3,
    ST_DONE  = 3'd4
  } state_e;

  state_e   stateR;
  logic [1:0] idxR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      idxR   <= 2'd0;
    end else begin
      case (stateR)
        ST_IDLE: if (start) begin
          stateR <= ST_ISSUE;
          idxR   <= 2'd0;
        end
        ST_ISSUE: stateR <= ST_WAIT;
        ST_WAIT: if (divDone) begin
          if (idxR == 2'(NUM_DIVS - 1)) stateR <= ST_PACK;
          else begin
            idxR   <= idxR + 2'd1;
            stateR <= ST_ISSUE;
          end
        end
        ST_PACK: stateR <= ST_DONE;
        ST_DONE: stateR <= ST_IDLE;
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.sel      = divSel_e'(idxR);
    strobe.loadRate = (stateR == ST_IDLE) && start;
    strobe.divStart = (stateR == ST_ISSUE);
    strobe.capture  = (stateR == ST_WAIT) && divDone;
    strobe.pack     = (stateR == ST_PACK);
  end

  assign busy = (stateR != ST_IDLE);
  assign done = (stateR == ST_DONE);

endmodule

// File: rtl/dphy_timing_datapath.sv
module dphy_timing_datapath
  import dphy_timing_pkg::*;
#(
  parameter int RATE_W  = 12,
  parameter int DIVISOR = 8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateMhz,
  input  ctrlStrobe_t       strobe,
  output logic              divDone,
  output logic              overflow,
  output logic [31:0]       word0,
  output logic [31:0]       word1,
  output logic [31:0]       word2,
  output logic [31:0]       word3
);

  localparam int NUM_W = RATE_W + 9;
  localparam int CW    = NUM_W + 3;

  logic [RATE_W-1:0] rateR;
  logic [NUM_W-1:0]  numer;
  logic [NUM_W-1:0]  divQuot;
  logic [NUM_W-1:0]  qR [NUM_DIVS];

  always_ff @(posedge clk) begin
    if (!rstN) rateR <= '0;
    else if (strobe.loadRate) rateR <= rateMhz;
  end

  always_comb begin
    case (strobe.sel)
      DIV_LPX:     numer = NUM_W'(rateR) * NUM_W'(LPX_MUL)     + NUM_W'(LPX_ADD);
      DIV_HSPREP:  numer = NUM_W'(rateR) * NUM_W'(HSPREP_MUL)  + NUM_W'(HSPREP_ADD);
      DIV_HSZERO:  numer = NUM_W'(rateR) * NUM_W'(HSZERO_MUL)  + NUM_W'(HSZERO_ADD);
      default:     numer = NUM_W'(rateR) * NUM_W'(CLKPREP_MUL) + NUM_W'(CLKPREP_ADD);
    endcase
  end

  dphy_serial_divider #(
    .NUM_W  (NUM_W),
    .DIVISOR(DIVISOR)
  ) div_i (
    .clk  (clk),
    .rstN (rstN),
    .start(strobe.divStart),
    .numer(numer),
    .quot (divQuot),
    .done (divDone)
  );

  for (genvar g = 0; g < NUM_DIVS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) qR[g] <= '0;
      else if (strobe.capture && (strobe.sel == divSel_e'(g))) qR[g] <= divQuot;
    end
  end

  // Derived counts
  logic [CW-1:0] lpx, hsPrep, hsZero, hsTrail;
  logic [CW-1:0] taGo, taSure, taGet, hsExit;
  logic [CW-1:0] clkPrep, clkPost, clkTrail, clkZero, clkExit;
  logic          zeroNeg;
  logic          anyBig;

  always_comb begin
    lpx      = CW'(qR[0]) + CW'(1);
    hsPrep   = CW'(qR[1]);
    zeroNeg  = (CW'(qR[2]) + CW'(1)) < hsPrep;
    hsZero   = CW'(qR[2]) + CW'(1) - hsPrep;
    hsTrail  = hsPrep + CW'(1);
    taGo     = (lpx << 2) - CW'(2);
    taSure   = lpx + CW'(2);
    taGet    = lpx << 2;
    hsExit   = (lpx << 1) + CW'(1);
    clkPrep  = CW'(qR[3]);
    clkPost  = clkPrep + CW'(8);
    clkTrail = clkPrep;
    clkZero  = clkTrail << 2;
    clkExit  = clkTrail << 1;
    anyBig   = (lpx > CW'(255)) || (hsPrep > CW'(255)) || (hsZero > CW'(255)) ||
               (hsTrail > CW'(255)) || (taGo > CW'(255)) || (taSure > CW'(255)) ||
               (taGet > CW'(255)) || (hsExit > CW'(255)) || (clkPost > CW'(255)) ||
               (clkZero > CW'(255)) || (clkExit > CW'(255));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0    <= '0;
      word1    <= '0;
      word2    <= '0;
      word3    <= '0;
      overflow <= 1'b0;
    end else if (strobe.pack) begin
      word0    <= {hsTrail[7:0], hsZero[7:0], hsPrep[7:0], lpx[7:0]};
      word1    <= {hsExit[7:0], taGet[7:0], taSure[7:0], taGo[7:0]};
      word2    <= {clkTrail[7:0], clkZero[7:0], 8'd1, 8'd0};
      word3    <= {8'd0, clkExit[7:0], clkPost[7:0], clkPrep[7:0]};
      overflow <= anyBig || zeroNeg;
    end
  end

endmodule

// File: rtl/dphy_timing_calc.sv
module dphy_timing_calc
  import dphy_timing_pkg::*;
#(
  parameter int RATE_W  = 12,
  parameter int DIVISOR = 8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [RATE_W-1:0] rateMhz,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [31:0]       timingWord0,
  output logic [31:0]       timingWord1,
  output logic [31:0]       timingWord2,
  output logic [31:0]       timingWord3
);

  ctrlStrobe_t strobe;
  logic        divDone;

  dphy_timing_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .divDone(divDone),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  dphy_timing_datapath #(
    .RATE_W (RATE_W),
    .DIVISOR(DIVISOR)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .rateMhz (rateMhz),
    .strobe  (strobe),
    .divDone (divDone),
    .overflow(overflow),
    .word0   (timingWord0),
    .word1   (timingWord1),
    .word2   (timingWord2),
    .word3   (timingWord3)
  );

endmodule

// File: rtl/dphy_timing_calc_chk.sv
module dphy_timing_calc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        overflow,
  input logic [31:0] w0,
  input logic [31:0] w1,
  input logic [31:0] w2,
  input logic [31:0] w3
);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r9_words_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(($stable(w0) && $stable(w1) && $stable(w2) && $stable(w3) && $stable(overflow))) |-> done);

  a_r5_fixed_fields: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (w2[15:0] == 16'h0100) && (w3[31:24] == 8'd0));

  a_r4_taget_from_lpx: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (w1[23:16] == {w0[5:0], 2'b00}));

  a_r6_clkpost_from_prep: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (w3[15:8] == w3[7:0] + 8'd8));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !overflow);

endmodule

bind dphy_timing_calc dphy_timing_calc_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .overflow(overflow),
  .w0      (timingWord0),
  .w1      (timingWord1),
  .w2      (timingWord2),
  .w3      (timingWord3)
);

// File: tb/dphy_timing_calc_tb.sv
module dphy_timing_calc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] rateMhz = '0;
  logic        busy, done, overflow;
  logic [31:0] timingWord0, timingWord1, timingWord2, timingWord3;

  int checks = 0;
  int errors = 0;
  int refLatency = -1;

  always #4 clk = ~clk;

  dphy_timing_calc dut_i (
    .clk(clk), .rstN(rstN), .start(start), .rateMhz(rateMhz),
    .busy(busy), .done(done), .overflow(overflow),
    .timingWord0(timingWord0), .timingWord1(timingWord1),
    .timingWord2(timingWord2), .timingWord3(timingWord3)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(int a, int b, int c, int d);
    return {8'(d), 8'(c), 8'(b), 8'(a)};
  endfunction

  task automatic expWords(int r, output logic [31:0] e0, output logic [31:0] e1,
                          output logic [31:0] e2, output logic [31:0] e3);
    int lpx, prep, zero, trail, cp;
    lpx   = 60 * r / 8000 + 1;
    prep  = (80 * r + 4000) / 8000;
    zero  = (170 * r + 10000) / 8000 + 1 - prep;
    trail = prep + 1;
    cp    = 70 * r / 8000;
    e0 = pk(lpx, prep, zero, trail);
    e1 = pk(4 * lpx - 2, lpx + 2, 4 * lpx, 2 * lpx + 1);
    e2 = pk(0, 1, 4 * cp, cp);
    e3 = pk(cp, cp + 8, 2 * cp, 0);
  endtask

  // Launch one computation and wait for done; returns latency in cycles
  task automatic runCalc(int r, output int lat);
    lat = 0;
    @(negedge clk);
    rateMhz = 12'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", 32'(busy), 32'd1);
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check("R2", "done seen", 32'(done), 32'd1);
  endtask

  task automatic checkResult(int r);
    logic [31:0] e0, e1, e2, e3;
    expWords(r, e0, e1, e2, e3);
    check("R3", $sformatf("word0 rate %0d", r), timingWord0, e0);
    check("R4", $sformatf("word1 rate %0d", r), timingWord1, e1);
    check("R5", $sformatf("word2 rate %0d", r), timingWord2, e2);
    check("R6", $sformatf("word3 rate %0d", r), timingWord3, e3);
    check("R8", $sformatf("overflow rate %0d", r), 32'(overflow), 32'd0);
  endtask

  task automatic testReset();
    check("R1", "word0", timingWord0, 32'd0);
    check("R1", "word1", timingWord1, 32'd0);
    check("R1", "word2", timingWord2, 32'd0);
    check("R1", "word3", timingWord3, 32'd0);
    check("R1", "done/busy/ovf", {29'd0, done, busy, overflow}, 32'd0);
  endtask

  task automatic testOne(int r);
    int lat;
    runCalc(r, lat);
    checkResult(r);
    if (refLatency < 0) refLatency = lat;
    check("R2", $sformatf("latency rate %0d", r), 32'(lat), 32'(refLatency));
    @(negedge clk);
    check("R2", "done one cycle", 32'(done), 32'd0);
    check("R2", "idle after done", 32'(busy), 32'd0);
  endtask

  task automatic testSweep();
    for (int r = 0; r < 4096; r += 97) testOne(r);
    testOne(4095);
  endtask

  task automatic testBusyIgnore();
    int lat;
    int extra;
    @(negedge clk);
    rateMhz = 12'd3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rateMhz = 12'd500;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check("R7", "done after ignored start", 32'(done), 32'd1);
    checkResult(3000);
    extra = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R7", "no extra done", 32'(extra), 32'd0);
    check("R7", "idle after run", 32'(busy), 32'd0);
  endtask

  task automatic testHold();
    logic [31:0] s0, s1, s2, s3;
    s0 = timingWord0; s1 = timingWord1; s2 = timingWord2; s3 = timingWord3;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rateMhz = 12'(i * 101);
    end
    check("R9", "word0 hold", timingWord0, s0);
    check("R9", "word1 hold", timingWord1, s1);
    check("R9", "word2 hold", timingWord2, s2);
    check("R9", "word3 hold", timingWord3, s3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOne(1000);
    testOne(0);
    testOne(4095);
    testOne(1500);
    testHold();
    testBusyIgnore();
    testSweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule